// File: doc/BRIEF.md
# Serial Register-Access Slave with Framed 24-Bit Transfers

This block terminates a four-wire serial bus (serial clock, active-low select, data in, data out) and turns each select window into one access to a small bank of 16-bit control registers. Every window carries one 24-bit frame, most significant bit first. The top bit marks a read. The next six bits give the register address. The following sixteen bits carry the data, and the last bit is a spare. On a read, the slave returns the addressed register in the data positions of the same frame. The register contents drive the control pins of a mixed-signal front end: circuit enables, a linearizer setting, an LO sideband select, I/Q phase trims, and converter control bits.

The serial inputs are oversampled by the system clock. Input bits are taken on rising serial-clock edges, and the returned bits change on falling edges. A write takes effect only when the select window closes after exactly 24 bits. A window that closes early or late raises a sticky alarm and changes nothing. An address outside the map also raises a sticky alarm. The alarm register clears each time it is read. Setting the soft-reset bit in the control register returns every register, alarms included, to its default, and the bit then reads back as zero.

Top module: `spi_reg_slave`

## Requirements
- R1: A 24-bit write frame to address 0x03 loads frame bits 9:1 into the nine enable outputs when select rises. Outputs change at no other time, and writing zero clears them all.
- R2: In a read frame (bit 23 = 1), the slave drives the addressed register on MISO in frame bits 16:1, MSB first. MISO is low in frame bits 23:17 and in bit 0, and it stays low while select is high.
- R3: Address 0x00 reads back {parity-enable bit at 15, 0 at 14:12, chip ID 0x0A at 11:4, revision 0x1 at 3:0}. Only bit 15 can be written.
- R4: Address 0x05 holds the sideband select at bit 10, the Q trim at bits 7:4 and the I trim at bits 3:0, each driven on its own output. The other bits read 0.
- R5: Address 0x04 keeps bits 7:0 as the linearizer output. Address 0x06 keeps bits 3:0 as the converter-control output. Address 0x02 keeps all 16 bits. Unkept bits read 0.
- R6: A write to 0x00 with data bit 14 set returns every register to 0, including the parity bit and the alarms. Bit 14 reads back as 0.
- R7: Only addresses 0x00–0x06 and 0x0C are mapped. Any frame to another address sets alarm bit 12 once its address is shifted in. A write to such an address is dropped, and a read from it returns 0. Writes to 0x01 and 0x0C are ignored, and 0x0C reads 0.
- R8: If select rises after fewer than 24 bits, alarm bit 14 is set and the frame writes nothing.
- R9: If select rises after more than 24 bits, alarm bit 13 is set and the frame writes nothing.
- R10: Alarm bits at 0x01 are sticky. A read of 0x01 returns them and clears them, so an immediate second read returns 0.
- R11: After the synchronous reset, all outputs and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the bus master |
| miso | output | 1 | Serial read data to the bus master |
| en_o | output | 9 | Circuit enables from address 0x03 |
| lin_o | output | 8 | Linearizer setting |
| lo_side_o | output | 1 | LO sideband select |
| q_trim_o | output | 4 | Q-path phase trim |
| i_trim_o | output | 4 | I-path phase trim |
| adc_ctl_o | output | 4 | Converter control bits |

## Verification
The main function is exercised with four patterns:
- Write frames with all ones, alternating bits and all zeros. These show which register bits are kept and which read as zero.
- Read-after-write frames. These separate the read path's bit placement from the write path's.
- Frames aimed at unmapped and read-only addresses. These show that a bad address or a protected register is rejected rather than aliased to a neighbour.
- Frames cut short or run long. These separate the count check from the address check, and their alarm reads show the sticky and clear-on-read behaviour.

A behavioural model follows every frame, and the block's outputs are compared with it on each idle clock.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;

  localparam logic [ADDR_W-1:0] A_CTL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_ALM  = 6'h01;
  localparam logic [ADDR_W-1:0] A_MSK  = 6'h02;
  localparam logic [ADDR_W-1:0] A_EN   = 6'h03;
  localparam logic [ADDR_W-1:0] A_LIN  = 6'h04;
  localparam logic [ADDR_W-1:0] A_LO   = 6'h05;
  localparam logic [ADDR_W-1:0] A_ADC  = 6'h06;
  localparam logic [ADDR_W-1:0] A_ADCO = 6'h0C;

  localparam int CTL_PAR_BIT  = 15;
  localparam int CTL_SRST_BIT = 14;
  localparam int ALM_FEW_BIT  = 14;
  localparam int ALM_MANY_BIT = 13;
  localparam int ALM_ADDR_BIT = 12;

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
    return (a <= A_ADC) || (a == A_ADCO);
  endfunction
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_reg_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                mosi,
  input  logic [DATA_W-1:0]   rdata,
  output logic                miso,
  output logic                dec_vld,
  output logic                dec_rd,
  output logic [ADDR_W-1:0]   dec_addr,
  output logic                end_vld,
  output logic [CNT_W-1:0]    end_cnt,
  output logic                end_rd,
  output logic [ADDR_W-1:0]   end_addr,
  output logic [DATA_W-1:0]   end_data
);
  localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_TX_FIRST = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] C_TX_LAST  = CNT_W'(FRAME_BITS - 2);
  localparam logic [CNT_W-1:0] C_SAT      = {CNT_W{1'b1}};

  logic [SYNC:0]           sclk_p, cs_p;
  logic [SYNC-1:0]         mosi_p;
  logic [FRAME_BITS-1:0]   sh;
  logic [DATA_W-1:0]       tx;
  logic [CNT_W-1:0]        cnt;

  logic rise, fall, act, cs_start, cs_stop, mosi_now;

  assign rise     =  sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign fall     = ~sclk_p[SYNC-1] &  sclk_p[SYNC];
  assign act      = ~cs_p[SYNC-1];
  assign cs_start =  cs_p[SYNC] & ~cs_p[SYNC-1];
  assign cs_stop  = ~cs_p[SYNC] &  cs_p[SYNC-1];
  assign mosi_now =  mosi_p[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      miso    <= 1'b0;
      dec_vld <= 1'b0;
      end_vld <= 1'b0;
      end_cnt <= '0;
    end else begin
      dec_vld <= 1'b0;
      end_vld <= 1'b0;
      if (cs_start) begin
        sh   <= '0;
        tx   <= '0;
        cnt  <= '0;
        miso <= 1'b0;
      end else if (cs_stop) begin
        end_vld <= 1'b1;
        end_cnt <= cnt;
        miso    <= 1'b0;
      end else if (act) begin
        if (rise) begin
          sh <= {sh[FRAME_BITS-2:0], mosi_now};
          if (cnt != C_SAT) cnt <= cnt + 1'b1;
          if (cnt == C_HDR_LAST) dec_vld <= 1'b1;
        end
        if (fall) begin
          if (cnt >= C_TX_FIRST && cnt <= C_TX_LAST) begin
            miso <= tx[DATA_W-1];
            tx   <= {tx[DATA_W-2:0], 1'b0};
          end else begin
            miso <= 1'b0;
          end
        end
        if (dec_vld) tx <= rdata;
      end
    end
  end

  assign dec_rd   = sh[ADDR_W];
  assign dec_addr = sh[ADDR_W-1:0];
  assign end_rd   = sh[FRAME_BITS-1];
  assign end_addr = sh[FRAME_BITS-2 -: ADDR_W];
  assign end_data = sh[DATA_W:1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h0A,
  parameter logic [3:0] REV     = 4'h1,
  parameter int         EN_W    = 9,
  parameter int         LIN_W   = 8,
  parameter int         TRIM_W  = 4,
  parameter int         ADC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_vld,
  input  logic               dec_rd,
  input  logic [ADDR_W-1:0]  dec_addr,
  output logic [DATA_W-1:0]  rdata,
  input  logic               end_vld,
  input  logic [CNT_W-1:0]   end_cnt,
  input  logic               end_rd,
  input  logic [ADDR_W-1:0]  end_addr,
  input  logic [DATA_W-1:0]  end_data,
  output logic [DATA_W-1:0]  alarm,
  output logic [EN_W-1:0]    en_o,
  output logic [LIN_W-1:0]   lin_o,
  output logic               lo_side_o,
  output logic [TRIM_W-1:0]  q_trim_o,
  output logic [TRIM_W-1:0]  i_trim_o,
  output logic [ADC_W-1:0]   adc_ctl_o
);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);
  localparam int SIDE_BIT = 10;

  logic              par_q;
  logic [DATA_W-1:0] mask_q;
  logic              wr_go, srst, alm_clr;
  logic [DATA_W-1:0] alm_set;

  assign wr_go   = end_vld && (end_cnt == C_FULL) && !end_rd && addr_mapped(end_addr);
  assign srst    = wr_go && (end_addr == A_CTL) && end_data[CTL_SRST_BIT];
  assign alm_clr = dec_vld && dec_rd && (dec_addr == A_ALM);

  always_comb begin
    alm_set = '0;
    alm_set[ALM_ADDR_BIT] = dec_vld && !addr_mapped(dec_addr);
    alm_set[ALM_FEW_BIT]  = end_vld && (end_cnt < C_FULL);
    alm_set[ALM_MANY_BIT] = end_vld && (end_cnt > C_FULL);
  end

  always_comb begin
    rdata = '0;
    unique case (dec_addr)
      A_CTL: rdata = {par_q, 3'b000, CHIP_ID, REV};
      A_ALM: rdata = alarm;
      A_MSK: rdata = mask_q;
      A_EN:  rdata = DATA_W'(en_o);
      A_LIN: rdata = DATA_W'(lin_o);
      A_LO:  rdata = {5'b0, lo_side_o, 2'b0, q_trim_o, i_trim_o};
      A_ADC: rdata = DATA_W'(adc_ctl_o);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      par_q     <= 1'b0;
      mask_q    <= '0;
      alarm     <= '0;
      en_o      <= '0;
      lin_o     <= '0;
      lo_side_o <= 1'b0;
      q_trim_o  <= '0;
      i_trim_o  <= '0;
      adc_ctl_o <= '0;
    end else begin
      alarm <= (alarm & ~{DATA_W{alm_clr}}) | alm_set;
      if (wr_go) begin
        unique case (end_addr)
          A_CTL: par_q  <= end_data[CTL_PAR_BIT];
          A_MSK: mask_q <= end_data;
          A_EN:  en_o   <= end_data[EN_W-1:0];
          A_LIN: lin_o  <= end_data[LIN_W-1:0];
          A_LO: begin
            lo_side_o <= end_data[SIDE_BIT];
            q_trim_o  <= end_data[2*TRIM_W-1:TRIM_W];
            i_trim_o  <= end_data[TRIM_W-1:0];
          end
          A_ADC: adc_ctl_o <= end_data[ADC_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int         SYNC    = 2,
  parameter logic [7:0] CHIP_ID = 8'h0A,
  parameter logic [3:0] REV     = 4'h1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic [8:0] en_o,
  output logic [7:0] lin_o,
  output logic       lo_side_o,
  output logic [3:0] q_trim_o,
  output logic [3:0] i_trim_o,
  output logic [3:0] adc_ctl_o
);
  logic              dec_vld, dec_rd, end_vld, end_rd;
  logic [ADDR_W-1:0] dec_addr, end_addr;
  logic [CNT_W-1:0]  end_cnt;
  logic [DATA_W-1:0] end_data, rdata, alarm;

  spi_frame_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .rdata(rdata), .miso(miso),
    .dec_vld(dec_vld), .dec_rd(dec_rd), .dec_addr(dec_addr),
    .end_vld(end_vld), .end_cnt(end_cnt), .end_rd(end_rd),
    .end_addr(end_addr), .end_data(end_data)
  );

  spi_reg_bank #(.CHIP_ID(CHIP_ID), .REV(REV)) u_bank (
    .clk(clk), .rst(rst),
    .dec_vld(dec_vld), .dec_rd(dec_rd), .dec_addr(dec_addr), .rdata(rdata),
    .end_vld(end_vld), .end_cnt(end_cnt), .end_rd(end_rd),
    .end_addr(end_addr), .end_data(end_data), .alarm(alarm),
    .en_o(en_o), .lin_o(lin_o), .lo_side_o(lo_side_o),
    .q_trim_o(q_trim_o), .i_trim_o(i_trim_o), .adc_ctl_o(adc_ctl_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              miso,
  input logic              dec_vld,
  input logic              dec_rd,
  input logic [ADDR_W-1:0] dec_addr,
  input logic              end_vld,
  input logic [CNT_W-1:0]  end_cnt,
  input logic              end_rd,
  input logic [ADDR_W-1:0] end_addr,
  input logic [DATA_W-1:0] end_data,
  input logic [DATA_W-1:0] alarm,
  input logic [8:0]        en_o,
  input logic [7:0]        lin_o,
  input logic [3:0]        adc_ctl_o
);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);

  p_miso_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

  p_outputs_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !end_vld |=> ($stable(en_o) && $stable(lin_o) && $stable(adc_ctl_o)));

  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (end_vld && end_cnt == C_FULL && !end_rd && end_addr == A_CTL && end_data[CTL_SRST_BIT])
    |=> (en_o == '0 && lin_o == '0 && adc_ctl_o == '0 && alarm == '0));

  p_bad_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && !addr_mapped(dec_addr)) |=> alarm[ALM_ADDR_BIT]);

  p_short_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (end_vld && end_cnt < C_FULL) |=> (alarm[ALM_FEW_BIT] && $stable(en_o) && $stable(lin_o)));

  p_long_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (end_vld && end_cnt > C_FULL) |=> (alarm[ALM_MANY_BIT] && $stable(en_o) && $stable(lin_o)));

  p_alarm_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && dec_rd && dec_addr == A_ALM && !end_vld) |=> (alarm == '0));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso),
  .dec_vld(dec_vld), .dec_rd(dec_rd), .dec_addr(dec_addr),
  .end_vld(end_vld), .end_cnt(end_cnt), .end_rd(end_rd),
  .end_addr(end_addr), .end_data(end_data), .alarm(alarm),
  .en_o(en_o), .lin_o(lin_o), .adc_ctl_o(adc_ctl_o)
);

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, lo_side_o;
  logic [8:0] en_o;
  logic [7:0] lin_o;
  logic [3:0] q_trim_o, i_trim_o, adc_ctl_o;

  spi_reg_slave dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .en_o(en_o), .lin_o(lin_o), .lo_side_o(lo_side_o),
    .q_trim_o(q_trim_o), .i_trim_o(i_trim_o), .adc_ctl_o(adc_ctl_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, idle = 1'b0;

  // behavioural model state
  logic        m_par = 1'b0, m_side = 1'b0;
  logic [15:0] m_mask = '0, m_alm = '0;
  logic [8:0]  m_en = '0;
  logic [7:0]  m_lin = '0;
  logic [3:0]  m_q = '0, m_i = '0, m_adc = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [5:0] a);
    return (a <= 6'h06) || (a == 6'h0C);
  endfunction

  function automatic logic [15:0] mread(input logic [5:0] a);
    case (a)
      6'h00: return {m_par, 3'b000, 8'h0A, 4'h1};
      6'h01: return m_alm;
      6'h02: return m_mask;
      6'h03: return {7'b0, m_en};
      6'h04: return {8'b0, m_lin};
      6'h05: return {5'b0, m_side, 2'b0, m_q, m_i};
      6'h06: return {12'b0, m_adc};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [31:0] m_outs();
    return {1'b0, m_en, m_lin, m_side, m_q, m_i, m_adc, 1'b0};
  endfunction

  function automatic logic [31:0] d_outs();
    return {1'b0, en_o, lin_o, lo_side_o, q_trim_o, i_trim_o, adc_ctl_o, miso};
  endfunction

  task automatic mframe(input logic [23:0] f, input int nb, output logic [15:0] exp);
    logic [5:0] a;
    a = f[22:17];
    exp = '0;
    if (nb >= 7) begin
      if (!mapped(a)) m_alm[12] = 1'b1;
      else if (f[23]) begin
        exp = mread(a);
        if (a == 6'h01) m_alm = '0;
      end
    end
    if (nb == 24 && !f[23] && mapped(a)) begin
      case (a)
        6'h00: if (f[15]) begin
                 m_par = 0; m_mask = '0; m_alm = '0; m_en = '0; m_lin = '0;
                 m_side = 0; m_q = '0; m_i = '0; m_adc = '0;
               end else m_par = f[16];
        6'h02: m_mask = f[16:1];
        6'h03: m_en = f[9:1];
        6'h04: m_lin = f[8:1];
        6'h05: begin m_side = f[11]; m_q = f[8:5]; m_i = f[4:1]; end
        6'h06: m_adc = f[4:1];
        default: ;
      endcase
    end
    if (nb < 24) m_alm[14] = 1'b1;
    if (nb > 24) m_alm[13] = 1'b1;
  endtask

  task automatic xfer(input logic [23:0] f, input int nb, output logic [23:0] rx);
    rx = '0;
    idle = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      mosi = (k < 24) ? f[23-k] : 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      if (k < 24) rx[23-k] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (3*HALF) @(negedge clk);
    idle = 1'b1;
  endtask

  task automatic txn(input logic rd, input logic [5:0] a, input logic [15:0] d,
                     input int nb, input string tag, output logic [15:0] got);
    logic [23:0] f, rx;
    logic [15:0] exp;
    f = {rd, a, d, 1'b0};
    mframe(f, nb, exp);
    xfer(f, nb, rx);
    got = rx[16:1];
    if (rd && nb == 24) begin
      chk(rx[16:1] == exp, tag, {16'h0, rx[16:1]}, {16'h0, exp});
      chk(rx[23:17] == 7'h0 && rx[0] == 1'b0, "R2 miso idle bits", {8'h0, rx}, 32'h0);
    end
    chk(d_outs() == m_outs(), tag, d_outs(), m_outs());
  endtask

  // per-clock comparison against the model while the bus is idle (R1 R2 R4 R5)
  always @(negedge clk) begin
    if (idle && !done && !rst)
      chk(d_outs() == m_outs(), "R1 R4 R5 idle outputs", d_outs(), m_outs());
  end

  initial begin
    logic [15:0] g;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(d_outs() == 32'h0, "R11 reset outputs", d_outs(), 32'h0);
    idle = 1'b1;

    txn(1'b1, 6'h01, 16'h0, 24, "R11 alarm after reset", g);
    txn(1'b1, 6'h00, 16'h0, 24, "R3 id read", g);
    txn(1'b0, 6'h00, 16'hBFFF, 24, "R3 ctl write", g);
    txn(1'b1, 6'h00, 16'h0, 24, "R3 ctl readback", g);

    txn(1'b0, 6'h03, 16'h01A5, 24, "R1 enable pattern", g);
    txn(1'b0, 6'h03, 16'hFFFF, 24, "R1 enable all ones", g);
    txn(1'b1, 6'h03, 16'h0, 24, "R2 enable readback", g);
    txn(1'b0, 6'h03, 16'h0000, 24, "R1 enable powerdown", g);
    txn(1'b0, 6'h03, 16'h0155, 24, "R1 enable alternating", g);

    txn(1'b0, 6'h05, 16'hFFFF, 24, "R4 lo all ones", g);
    txn(1'b1, 6'h05, 16'h0, 24, "R4 lo readback", g);
    txn(1'b0, 6'h05, 16'h0412, 24, "R4 lo fields", g);
    txn(1'b1, 6'h05, 16'h0, 24, "R4 lo readback 2", g);

    txn(1'b0, 6'h04, 16'h12AB, 24, "R5 lin write", g);
    txn(1'b1, 6'h04, 16'h0, 24, "R5 lin readback", g);
    txn(1'b0, 6'h06, 16'hFFFA, 24, "R5 adc write", g);
    txn(1'b1, 6'h06, 16'h0, 24, "R5 adc readback", g);
    txn(1'b0, 6'h02, 16'hBEEF, 24, "R5 mask write", g);
    txn(1'b1, 6'h02, 16'h0, 24, "R5 mask readback", g);

    txn(1'b0, 6'h07, 16'h1234, 24, "R7 unmapped write", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R7 addr alarm", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R10 alarm cleared", g);
    txn(1'b1, 6'h3F, 16'h0, 24, "R7 unmapped read zero", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R7 addr alarm on read", g);
    txn(1'b0, 6'h0C, 16'hFFFF, 24, "R7 adc-out write ignored", g);
    txn(1'b1, 6'h0C, 16'h0, 24, "R7 adc-out reads zero", g);
    txn(1'b0, 6'h01, 16'hFFFF, 24, "R7 alarm write ignored", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R7 alarm still zero", g);

    txn(1'b0, 6'h03, 16'h0000, 20, "R8 short write dropped", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R8 short alarm", g);
    txn(1'b0, 6'h03, 16'h0000, 3, "R8 very short frame", g);
    txn(1'b0, 6'h03, 16'h0000, 28, "R9 long write dropped", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R9 R10 alarm read", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R10 second read zero", g);

    txn(1'b0, 6'h07, 16'h0, 24, "R6 prime alarm", g);
    txn(1'b0, 6'h00, 16'hC000, 24, "R6 soft reset", g);
    txn(1'b1, 6'h00, 16'h0, 24, "R6 ctl after soft reset", g);
    txn(1'b1, 6'h05, 16'h0, 24, "R6 lo after soft reset", g);
    txn(1'b1, 6'h02, 16'h0, 24, "R6 mask after soft reset", g);
    txn(1'b1, 6'h01, 16'h0, 24, "R6 alarm after soft reset", g);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule